// File: doc/BRIEF.md
# Fixed-Width Register Access Endpoint

This block terminates an inbound byte stream that carries writes and reads aimed at a small bank of gateware registers, and produces the matching outbound response stream. Each register's size in bytes is fixed when the design is built. Because of that, no length ever travels on the wire. A command byte names the register and says whether it is a read or a write, and the data bytes that follow are counted from that register's size. Several writes may be sent one after another in the same stream.

Every command gets exactly one response, and responses go out in command order. A write is answered by a single empty acknowledgement transfer. A read is answered by the register contents. A write is committed to the register bank in the same clock edge on which its acknowledgement is accepted downstream. Software that waits for the acknowledgement therefore knows the write is ordered ahead of everything that comes back after it.

A command byte naming a register that does not exist raises a sticky error flag. The endpoint then throws away input up to and including the next byte marked end-of-packet. If the response side stalls, the endpoint stops taking input until the pending response has left.

Top module: `regx_endpoint`

## Requirements
- R1: A command byte carries the access type in bit 7 (1 = read, 0 = write) and the register index in bits 6:0. Valid indices are 0 to NUM_REGS-1. Register i is REG_BYTES[3i+2:3i] bytes wide, and the default widths for registers 0 to 3 are 1, 3, 1 and 2 bytes.
- R2: A write command is followed by exactly as many data bytes as its register is wide, sent most-significant byte first. The next command byte follows directly, with no length field.
- R3: Each write produces exactly one response transfer with out_last high, out_dvalid low and out_data 0x00.
- R4: A write changes regs_o only on the clock edge where its acknowledgement is accepted (out_valid and out_ready both high). Before that edge the register keeps its old value.
- R5: A read produces as many transfers as the register is wide. Bytes go most-significant first with out_dvalid high, and out_last is high on the final byte only.
- R6: Each valid command produces exactly one response, and responses leave in the order the commands arrived.
- R7: While a response is pending, in_ready is low. While out_valid is high and out_ready is low, out_data, out_last and out_dvalid hold their values. No response is ever dropped.
- R8: A command byte with an index of NUM_REGS or above sets err_o, which stays high until reset. It produces no response and changes no register. Input bytes are then accepted and discarded up to and including the next byte with in_last high. If the bad command byte itself has in_last high, the discard ends with that byte.
- R9: After reset, regs_o is all zero, err_o is low, out_valid is low and in_ready is high.
- R10: in_last on any byte of a well-formed command has no effect, because framing comes only from the register widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Inbound byte |
| in_valid | input | 1 | Inbound byte present |
| in_last | input | 1 | Inbound end-of-packet marker |
| in_ready | output | 1 | Endpoint accepts the inbound byte |
| out_data | output | 8 | Response byte (0x00 for acknowledgements) |
| out_valid | output | 1 | Response transfer present |
| out_last | output | 1 | Response end-of-packet |
| out_dvalid | output | 1 | Response transfer carries a data byte |
| out_ready | input | 1 | Downstream accepts the response transfer |
| err_o | output | 1 | Sticky unknown-register error |
| regs_o | output | 32*NUM_REGS | Register contents, register i in bits 32i+31:32i, zero-extended |

## Verification
The bench writes every register with walking-one, all-ones, zero and arithmetic patterns, then reads each one back. This separates byte-order and width-framing faults from data-path faults. A long mixed sequence of reads and writes, driven both with an always-ready output and with a pseudo-random stall pattern, is compared against a model queue. That run exposes reordered, duplicated or lost responses, and any commit that drifts relative to acknowledgement acceptance. Separate cases cover a write held back by a stalled acknowledgement, bad indices with and without an immediate end-of-packet marker, end-of-packet markers placed inside well-formed writes, and a back-to-back burst of three writes.

// File: rtl/regx_pkg.sv
// Shared definitions for the register access endpoint.
// Assumes command bytes carry the read flag in bit 7.
package regx_pkg;

    localparam int CMD_RD_BIT = 7;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_DATA,
        ST_ACK,
        ST_READ,
        ST_DROP
    } regx_state_e;

endpackage

// File: rtl/regx_decode.sv
// Command byte decoder: splits a command byte into access type, index,
// index validity and the register's byte count minus one.
// Assumes every entry of REG_BYTES is in 1..4.
module regx_decode #(
    parameter int NUM_REGS = 4,
    parameter logic [3*NUM_REGS-1:0] REG_BYTES = 12'b010_001_011_001,
    localparam int IDXW = $clog2(NUM_REGS)
) (
    input  logic [7:0]      cmd,
    output logic            known,
    output logic            is_read,
    output logic [IDXW-1:0] idx,
    output logic [1:0]      nb_m1
);
    import regx_pkg::*;

    localparam logic [6:0] NREG7 = 7'(NUM_REGS);

    // Classify the command byte.
    always_comb begin
        is_read = cmd[CMD_RD_BIT];
        known   = (cmd[6:0] < NREG7);
        idx     = cmd[IDXW-1:0];
    end

    // Look up the byte count of the indexed register.
    always_comb begin
        nb_m1 = 2'd0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDXW'(i)) begin
                nb_m1 = 2'(REG_BYTES[3*i +: 3] - 3'd1);
            end
        end
    end

endmodule

// File: rtl/regx_bank.sv
// Register storage: one register per index, each exactly as wide as its
// byte count. Writes are committed when wr_en is high. A byte mux serves
// reads. Assumes wr_data holds the written value right-aligned.
module regx_bank #(
    parameter int NUM_REGS = 4,
    parameter logic [3*NUM_REGS-1:0] REG_BYTES = 12'b010_001_011_001,
    localparam int IDXW = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDXW-1:0]         wr_idx,
    input  logic [31:0]             wr_data,
    input  logic [IDXW-1:0]         rd_idx,
    input  logic [1:0]              rd_sel,
    output logic [7:0]              rd_byte,
    output logic [32*NUM_REGS-1:0]  regs_o
);

    logic [31:0] words [NUM_REGS];
    logic        unused_wr_hi;

    assign unused_wr_hi = ^wr_data;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam int NB = int'(REG_BYTES[3*i +: 3]);
        logic [8*NB-1:0] val;

        // Hold the register and commit a write aimed at this index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val <= '0;
            end else if (wr_en && (wr_idx == IDXW'(i))) begin
                val <= wr_data[8*NB-1:0];
            end
        end

        // Zero-extend the register to a 32-bit word.
        always_comb begin
            words[i]           = '0;
            words[i][8*NB-1:0] = val;
        end

        assign regs_o[32*i +: 32] = words[i];
    end

    // Select the requested byte of the requested register.
    always_comb begin
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDXW'(i)) begin
                w = words[i];
            end
        end
        rd_byte = w[{rd_sel, 3'b000} +: 8];
    end

endmodule

// File: rtl/regx_ctrl.sv
// Endpoint sequencer: takes command and data bytes, gathers write data
// most-significant byte first, issues one acknowledgement or one read
// burst per command, and discards input after a bad index until
// end-of-packet. Assumes decode outputs are valid for in_data.
module regx_ctrl #(
    parameter int NUM_REGS = 4,
    localparam int IDXW = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      in_data,
    input  logic            in_valid,
    input  logic            in_last,
    output logic            in_ready,
    input  logic            dec_known,
    input  logic            dec_read,
    input  logic [IDXW-1:0] dec_idx,
    input  logic [1:0]      dec_nb_m1,
    output logic            out_valid,
    output logic            out_last,
    output logic            out_dvalid,
    input  logic            out_ready,
    output logic [IDXW-1:0] cur_idx,
    output logic [1:0]      cnt,
    output logic            wr_en,
    output logic [31:0]     wr_data,
    output logic            err
);
    import regx_pkg::*;

    regx_state_e state;
    logic        in_hs;
    logic        out_hs;

    // Decode handshake and output qualifiers from the current state.
    always_comb begin
        in_ready   = (state == ST_CMD) || (state == ST_DATA) || (state == ST_DROP);
        out_valid  = (state == ST_ACK) || (state == ST_READ);
        out_dvalid = (state == ST_READ);
        out_last   = (state == ST_ACK) || ((state == ST_READ) && (cnt == 2'd0));
        in_hs      = in_valid && in_ready;
        out_hs     = out_valid && out_ready;
        wr_en      = (state == ST_ACK) && out_ready;
    end

    // Advance the command sequence and collect write bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CMD;
            cnt     <= 2'd0;
            cur_idx <= '0;
            wr_data <= '0;
            err     <= 1'b0;
        end else begin
            case (state)
                ST_CMD: if (in_hs) begin
                    if (!dec_known) begin
                        err   <= 1'b1;
                        state <= in_last ? ST_CMD : ST_DROP;
                    end else begin
                        cur_idx <= dec_idx;
                        cnt     <= dec_nb_m1;
                        state   <= dec_read ? ST_READ : ST_DATA;
                    end
                end
                ST_DATA: if (in_hs) begin
                    wr_data <= {wr_data[23:0], in_data};
                    if (cnt == 2'd0) state <= ST_ACK;
                    else             cnt   <= cnt - 2'd1;
                end
                ST_ACK: if (out_hs) begin
                    state <= ST_CMD;
                end
                ST_READ: if (out_hs) begin
                    if (cnt == 2'd0) state <= ST_CMD;
                    else             cnt   <= cnt - 2'd1;
                end
                ST_DROP: if (in_hs && in_last) begin
                    state <= ST_CMD;
                end
                default: state <= ST_CMD;
            endcase
        end
    end

    // A pending response blocks input.
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // A stalled response keeps its framing.
    assert_hold_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_last) && $stable(out_dvalid)));

    // An empty transfer is always a complete acknowledgement.
    assert_ack_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_dvalid) |-> out_last);

    // The error flag never clears without reset.
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

// File: rtl/regx_endpoint.sv
// Fixed-width register access endpoint: decodes inbound commands, keeps
// the register bank and returns acknowledgements and read data in order.
// Assumes NUM_REGS in 3..8 and every register 1..4 bytes wide.
module regx_endpoint #(
    parameter int NUM_REGS = 4,
    parameter logic [3*NUM_REGS-1:0] REG_BYTES = 12'b010_001_011_001
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             in_data,
    input  logic                   in_valid,
    input  logic                   in_last,
    output logic                   in_ready,
    output logic [7:0]             out_data,
    output logic                   out_valid,
    output logic                   out_last,
    output logic                   out_dvalid,
    input  logic                   out_ready,
    output logic                   err_o,
    output logic [32*NUM_REGS-1:0] regs_o
);
    localparam int IDXW = $clog2(NUM_REGS);

    logic            dec_known;
    logic            dec_read;
    logic [IDXW-1:0] dec_idx;
    logic [1:0]      dec_nb_m1;
    logic [IDXW-1:0] cur_idx;
    logic [1:0]      cnt;
    logic            wr_en;
    logic [31:0]     wr_data;
    logic [7:0]      rd_byte;

    regx_decode #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES)) decode_i (
        .cmd     (in_data),
        .known   (dec_known),
        .is_read (dec_read),
        .idx     (dec_idx),
        .nb_m1   (dec_nb_m1)
    );

    regx_ctrl #(.NUM_REGS(NUM_REGS)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .dec_known  (dec_known),
        .dec_read   (dec_read),
        .dec_idx    (dec_idx),
        .dec_nb_m1  (dec_nb_m1),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .out_dvalid (out_dvalid),
        .out_ready  (out_ready),
        .cur_idx    (cur_idx),
        .cnt        (cnt),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .err        (err_o)
    );

    regx_bank #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (cur_idx),
        .wr_data (wr_data),
        .rd_idx  (cur_idx),
        .rd_sel  (cnt),
        .rd_byte (rd_byte),
        .regs_o  (regs_o)
    );

    // Acknowledgements carry no data byte.
    always_comb begin
        out_data = out_dvalid ? rd_byte : 8'h00;
    end

    // Registers move only on an accepted acknowledgement.
    assert_commit_at_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_ready && !out_dvalid) |=> $stable(regs_o));

    // A stalled response keeps its byte.
    assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));

endmodule

// File: tb/regx_endpoint_tb.sv
`timescale 1ns/1ps
module regx_endpoint_tb_top;

    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic [7:0]    out_data;
    logic          out_valid;
    logic          out_last;
    logic          out_dvalid;
    logic          out_ready = 1'b1;
    logic          err_o;
    logic [32*NR-1:0] regs_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit hold_ready = 0;
    bit stall_mode = 0;
    logic [15:0] stall_lfsr = 16'hace1;
    logic [15:0] op_lfsr = 16'h1d2b;
    logic [31:0] model [NR];
    logic [9:0] rsp_q [$];
    logic [9:0] exp_q [$];

    regx_endpoint #(.NUM_REGS(NR), .REG_BYTES(12'b010_001_011_001)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_last(out_last), .out_dvalid(out_dvalid),
        .out_ready(out_ready), .err_o(err_o), .regs_o(regs_o)
    );

    always #2 clk = ~clk;

    function automatic int wid(input int i);
        return (i == 1) ? 3 : (i == 3) ? 2 : 1;
    endfunction

    function automatic logic [31:0] mask(input int i, input logic [31:0] v);
        logic [63:0] m;
        m = (64'd1 << (8 * wid(i))) - 64'd1;
        return v & m[31:0];
    endfunction

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Output monitor: set out_ready for the coming edge, then log a handshake.
    always @(negedge clk) begin
        if (hold_ready) out_ready = 1'b0;
        else if (stall_mode) begin
            stall_lfsr = step(stall_lfsr);
            out_ready = stall_lfsr[0] | stall_lfsr[5];
        end else out_ready = 1'b1;
        if (rst_n && out_valid && out_ready)
            rsp_q.push_back({out_dvalid, out_last, out_data});
    end

    // Present one byte, starting at a falling edge; returns after acceptance.
    task automatic send_byte(input logic [7:0] b, input logic last);
        bit r;
        in_data = b; in_valid = 1'b1; in_last = last;
        forever begin
            r = in_ready;
            @(negedge clk);
            if (r) break;
        end
    endtask

    task automatic idle_in();
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic do_write(input int i, input logic [31:0] v, input int last_at);
        send_byte(8'(i), 1'b0);
        for (int b = wid(i) - 1; b >= 0; b--)
            send_byte(v[8*b +: 8], (b == last_at));
        exp_q.push_back(10'b01_0000_0000);
        model[i] = mask(i, v);
    endtask

    task automatic do_read(input int i);
        send_byte(8'h80 | 8'(i), 1'b0);
        for (int b = wid(i) - 1; b >= 0; b--)
            exp_q.push_back({1'b1, (b == 0), model[i][8*b +: 8]});
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        idle_in();
        while (rsp_q.size() < exp_q.size() && t < 3000) begin
            @(negedge clk); t++;
        end
        repeat (3) @(negedge clk);
        chk(rsp_q.size() == exp_q.size(), req, "response count",
            rsp_q.size(), exp_q.size());
        if (rsp_q.size() == exp_q.size())
            foreach (exp_q[k]) chk(rsp_q[k] == exp_q[k], req, "response {dvalid,last,data}",
                                   rsp_q[k], exp_q[k]);
        for (int i = 0; i < NR; i++)
            chk(regs_o[32*i +: 32] == model[i], req, $sformatf("reg%0d value", i),
                regs_o[32*i +: 32], model[i]);
        rsp_q.delete();
        exp_q.delete();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(out_valid == 1'b0, "R9", "out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R9", "in_ready", in_ready, 1);
        chk(err_o == 1'b0, "R9", "err_o", err_o, 0);
        chk(regs_o == '0, "R9", "regs_o", regs_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3: back-to-back writes to 1-, 3- and 1-byte registers
        do_write(0, 32'haa, -1);
        do_write(1, 32'habcdef, -1);
        do_write(2, 32'hff, -1);
        drain("R2");

        // R1, R5: sweep of read type and MSB-first byte order per register
        for (int s = 0; s < 2; s++) begin
            stall_mode = (s == 1);
            for (int i = 0; i < NR; i++) begin
                for (int k = 0; k < 8 * wid(i); k++) begin
                    do_write(i, 32'd1 << k, -1);
                    do_read(i);
                end
                do_write(i, 32'hffffffff, -1); do_read(i);
                do_write(i, 32'h0, -1);        do_read(i);
                do_write(i, 32'h9e3779b9 * (i + 3), -1); do_read(i);
                drain("R5");
            end
        end
        stall_mode = 0;

        // R4, R7: acknowledgement stalled, write must not land yet
        do_write(3, 32'h1234, -1);
        drain("R4");
        hold_ready = 1;
        send_byte(8'h03, 1'b0); send_byte(8'hbe, 1'b0); send_byte(8'hef, 1'b0);
        in_data = 8'h80; in_last = 1'b0;   // next command waits
        repeat (6) @(negedge clk);
        chk(out_valid && out_last && !out_dvalid, "R3", "stalled ack shape",
            {out_valid, out_last, out_dvalid}, 3'b110);
        chk(in_ready == 1'b0, "R7", "in_ready while ack pending", in_ready, 0);
        chk(regs_o[96 +: 32] == 32'h1234, "R4", "reg3 before ack accepted",
            regs_o[96 +: 32], 32'h1234);
        idle_in();
        hold_ready = 0;
        exp_q.push_back(10'b01_0000_0000);
        model[3] = 32'hbeef;
        drain("R4");

        // R10: in_last inside a write does not cut it short
        do_write(1, 32'h13579b, 2);
        do_read(1);
        drain("R10");

        // R8: unknown index, discard through in_last
        send_byte(8'h7f, 1'b0);
        send_byte(8'h00, 1'b0);
        send_byte(8'h11, 1'b0);
        chk(in_ready == 1'b1, "R8", "in_ready during discard", in_ready, 1);
        send_byte(8'h22, 1'b1);
        drain("R8");
        chk(err_o == 1'b1, "R8", "err_o set", err_o, 1);
        // R8: bad read index with in_last on the same byte ends discard at once
        send_byte(8'h84, 1'b1);
        do_write(2, 32'h5c, -1);
        do_read(0);
        drain("R8");
        chk(err_o == 1'b1, "R8", "err_o sticky", err_o, 1);

        // R6: long mixed sequence with random stalls
        stall_mode = 1;
        for (int n = 0; n < 300; n++) begin
            int i;
            op_lfsr = step(op_lfsr);
            i = int'(op_lfsr[1:0]);
            if (op_lfsr[4]) do_read(i);
            else do_write(i, {op_lfsr, step(op_lfsr)}, -1);
            if (n % 50 == 49) drain("R6");
        end
        drain("R6");
        stall_mode = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule